// File: doc/BRIEF.md
# Tape Controller Command and Status Front End

This block is the register-side front end of a controller that serves a small set of magnetic tape drives (four by default). The processor writes an 8-bit command byte aimed at one drive. The block checks the low six bits against a sparse set of legal operation codes and weighs the state of the drive: whether it is present, whether it is write-locked, and whether it is already moving. It then either drops the byte silently or launches the operation. A launch raises a one-cycle start strobe that carries the code and the drive index to the transfer engine, which sits outside this block. In the same cycle, a cancel mask tells the engine which other drives must abandon their work.

The block also holds the controller status. Four flags are shared by the whole controller: error, end of file, busy and end of medium. Two flags are kept for each drive: end of tape and no motion. The engine sets or clears these flags with single-cycle pulses. On the status port the block assembles one byte for the selected drive. When that drive is absent, the byte shows a device-unavailable bit in place of the per-drive flags. The byte also carries an exception summary bit. Each drive has an interrupt arm bit, changed by the two top bits of every command byte, and a pending-interrupt bit that the engine raises and the processor acknowledges.

Top module: `tape_cmd_front`

## Requirements
- R1: The operation code is `cmd_byte[5:0]`. The only legal codes are 0x11, 0x13, 0x20, 0x21, 0x22, 0x23, 0x30 and 0x38. A write carrying any other code raises no start strobe and changes no status flag.
- R2: Code 0x20 clears the controller whatever the state of the drive (absent, locked or active). It sets busy and clears error, end of file, end of medium, the transfer flag, every arm bit and every pending interrupt. It sets no motion on every drive, keeps every end-of-tape flag, raises all bits of `cancel_mask` for one cycle and raises no start strobe.
- R3: A legal code other than 0x20, sent to a drive whose `drv_attached` bit is low, is ignored.
- R4: Code 0x22 (write) or 0x30 (write file mark) sent to a drive whose `drv_wlock` bit is high is ignored. Other codes to that drive are accepted.
- R5: A command to a drive whose `eng_active` bit is high is ignored, unless that drive's `eng_stopping` bit is also high.
- R6: One cycle after an accepted command, `start_pulse` is high for one cycle with `start_code` and `start_drive` equal to the command. In that same cycle, `cancel_mask` marks every other drive that is active and not rewinding.
- R7: After acceptance, busy is clear for codes 0x22 and 0x38 and set for the other codes. Error, end of file and end of medium are clear. The addressed drive's end-of-tape and no-motion flags are clear. `xfer_on` is high only for codes 0x21 and 0x22; a pulse on `eng_xfer_clr` drops it.
- R8: `sts_byte` for the drive named by `drv_sel` has this layout: bit 7 error, bit 6 end of file, bit 5 end of tape, bit 4 no motion, bit 3 busy, bit 2 exception, bit 1 end of medium, bit 0 device unavailable.
- R9: When the selected drive is absent, bits 5 and 4 read 0 and bit 0 reads 1. When it is present, bit 0 reads 0.
- R10: Bit 2 is 1 exactly when bit 7, bit 6 or bit 4 of the same byte is 1.
- R11: On every command write, `cmd_byte[6]` arms the addressed drive and `cmd_byte[7]` disarms it; disarm wins when both are set. This holds whether or not the code is legal. An `eng_intr` pulse sets the pending bit (`irq`) of `eng_drive` only if that drive is armed. `irq_ack` clears pending bits.
- R12: After reset, busy and no motion are set on every drive, and every other flag, arm bit, pending bit, strobe and mask is 0.
- R13: Engine pulses update the flags one cycle later. When a clear or an accepted command lands in the same cycle, the command's flag values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| drv_sel | input | SEL_W | Drive addressed by command and status |
| cmd_byte | input | 8 | Command byte: code in [5:0], arm [6], disarm [7] |
| sts_byte | output | 8 | Status byte of the selected drive |
| drv_attached | input | NUM_DRV | Drive present with medium |
| drv_wlock | input | NUM_DRV | Drive write-locked |
| eng_active | input | NUM_DRV | Engine has an operation running on the drive |
| eng_stopping | input | NUM_DRV | Drive's operation is in a stop stage |
| eng_rewind | input | NUM_DRV | Drive's running operation is a rewind |
| eng_drive | input | SEL_W | Drive index for the engine per-drive pulses |
| eng_set_err | input | 1 | Set error |
| eng_set_eof | input | 1 | Set end of file |
| eng_set_eom | input | 1 | Set end of medium |
| eng_busy_set | input | 1 | Set busy |
| eng_busy_clr | input | 1 | Clear busy (wins over set) |
| eng_set_eot | input | 1 | Set end of tape on eng_drive |
| eng_set_nmtn | input | 1 | Set no motion on eng_drive |
| eng_xfer_clr | input | 1 | Clear transfer-in-progress |
| eng_intr | input | 1 | Interrupt request for eng_drive |
| irq_ack | input | NUM_DRV | Clear pending interrupt per drive |
| start_pulse | output | 1 | One-cycle operation start |
| start_code | output | 6 | Code of the started operation |
| start_drive | output | SEL_W | Drive of the started operation |
| cancel_mask | output | NUM_DRV | One-cycle per-drive cancel request |
| xfer_on | output | 1 | Data transfer in progress |
| irq | output | NUM_DRV | Pending interrupt per drive |

## Verification
The bench targets the decisions that a wrong gate would invert. Neighbour codes of legal ones (0x12, 0x3F, 0x00) must be dropped; a design with a loose decode would start them. Write and write file mark to a locked drive must be refused while a read to that drive still starts; a design that refuses by drive alone would block the read. An active drive must refuse a command unless it is stopping, and a cancel must spare a rewinding drive and the addressed drive itself. Beyond these, the bench checks that a clear keeps end of tape while it wipes arm bits that were set in the same byte, that the exception bit follows no motion only while the drive is present, and that a same-cycle engine error is overridden by an accepted command but kept on an ignored one.

// File: rtl/tcf_pkg.sv
`timescale 1ns/1ps
package tcf_pkg;

    localparam int CODE_W = 6;

    typedef enum logic [CODE_W-1:0] {
        OP_BACK_REC  = 6'h11,
        OP_BACK_FILE = 6'h13,
        OP_CLEAR     = 6'h20,
        OP_READ      = 6'h21,
        OP_WRITE     = 6'h22,
        OP_FWD_FILE  = 6'h23,
        OP_MARK      = 6'h30,
        OP_REWIND    = 6'h38
    } tape_op_e;

    // status byte bit positions
    localparam int SB_ERR  = 7;
    localparam int SB_EOF  = 6;
    localparam int SB_EOT  = 5;
    localparam int SB_NMT  = 4;
    localparam int SB_BSY  = 3;
    localparam int SB_EXC  = 2;
    localparam int SB_EOM  = 1;
    localparam int SB_UNA  = 0;

    // command byte control bits
    localparam int CB_ARM    = 6;
    localparam int CB_DISARM = 7;

    typedef struct packed {
        logic legal;
        logic is_clear;
        logic is_wr_class;
        logic busy_on_start;
        logic is_xfer;
    } op_dec_t;

endpackage

// File: rtl/tcf_cmd_decode.sv
`timescale 1ns/1ps
module tcf_cmd_decode
    import tcf_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output op_dec_t           dec_o
);

    always_comb begin
        dec_o = '0;
        case (code_i)
            OP_BACK_REC, OP_BACK_FILE, OP_CLEAR, OP_READ,
            OP_WRITE, OP_FWD_FILE, OP_MARK, OP_REWIND: dec_o.legal = 1'b1;
            default:                                   dec_o.legal = 1'b0;
        endcase
        dec_o.is_clear      = (code_i == OP_CLEAR);
        dec_o.is_wr_class   = (code_i == OP_WRITE) || (code_i == OP_MARK);
        dec_o.busy_on_start = !((code_i == OP_WRITE) || (code_i == OP_REWIND));
        dec_o.is_xfer       = (code_i == OP_READ) || (code_i == OP_WRITE);
    end

endmodule

// File: rtl/tcf_accept.sv
`timescale 1ns/1ps
module tcf_accept
    import tcf_pkg::*;
#(
    parameter int NUM_DRV = 4,
    localparam int SEL_W  = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
    input  logic               cmd_wr_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  op_dec_t            dec_i,
    input  logic [NUM_DRV-1:0] attached_i,
    input  logic [NUM_DRV-1:0] wlock_i,
    input  logic [NUM_DRV-1:0] active_i,
    input  logic [NUM_DRV-1:0] stopping_i,
    input  logic [NUM_DRV-1:0] rewind_i,
    output logic               accept_o,
    output logic               clear_o,
    output logic [NUM_DRV-1:0] cancel_o
);

    logic present_w;
    logic locked_w;
    logic blocked_w;

    always_comb begin
        present_w = attached_i[sel_i];
        locked_w  = dec_i.is_wr_class && wlock_i[sel_i];
        blocked_w = active_i[sel_i] && !stopping_i[sel_i];
        clear_o   = cmd_wr_i && dec_i.is_clear;
        accept_o  = cmd_wr_i && dec_i.legal && !dec_i.is_clear &&
                    present_w && !locked_w && !blocked_w;
    end

    // a running rewind and the addressed drive are spared
    for (genvar gi = 0; gi < NUM_DRV; gi++) begin : g_cancel
        assign cancel_o[gi] = active_i[gi] && !rewind_i[gi] &&
                              (sel_i != SEL_W'(gi));
    end

endmodule

// File: rtl/tcf_status_mux.sv
`timescale 1ns/1ps
module tcf_status_mux
    import tcf_pkg::*;
#(
    parameter int NUM_DRV = 4,
    localparam int SEL_W  = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               err_i,
    input  logic               eof_i,
    input  logic               busy_i,
    input  logic               eom_i,
    input  logic [NUM_DRV-1:0] eot_i,
    input  logic [NUM_DRV-1:0] nmt_i,
    input  logic [NUM_DRV-1:0] attached_i,
    output logic [7:0]         sts_o
);

    logic present_w;
    logic eot_w;
    logic nmt_w;

    always_comb begin
        present_w     = attached_i[sel_i];
        eot_w         = present_w && eot_i[sel_i];
        nmt_w         = present_w && nmt_i[sel_i];
        sts_o         = '0;
        sts_o[SB_ERR] = err_i;
        sts_o[SB_EOF] = eof_i;
        sts_o[SB_EOT] = eot_w;
        sts_o[SB_NMT] = nmt_w;
        sts_o[SB_BSY] = busy_i;
        sts_o[SB_EXC] = err_i || eof_i || nmt_w;
        sts_o[SB_EOM] = eom_i;
        sts_o[SB_UNA] = !present_w;
    end

endmodule

// File: rtl/tape_cmd_front.sv
`timescale 1ns/1ps
module tape_cmd_front
    import tcf_pkg::*;
#(
    parameter int NUM_DRV = 4,
    localparam int SEL_W  = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [SEL_W-1:0]   drv_sel,
    input  logic [7:0]         cmd_byte,
    output logic [7:0]         sts_byte,
    input  logic [NUM_DRV-1:0] drv_attached,
    input  logic [NUM_DRV-1:0] drv_wlock,
    input  logic [NUM_DRV-1:0] eng_active,
    input  logic [NUM_DRV-1:0] eng_stopping,
    input  logic [NUM_DRV-1:0] eng_rewind,
    input  logic [SEL_W-1:0]   eng_drive,
    input  logic               eng_set_err,
    input  logic               eng_set_eof,
    input  logic               eng_set_eom,
    input  logic               eng_busy_set,
    input  logic               eng_busy_clr,
    input  logic               eng_set_eot,
    input  logic               eng_set_nmtn,
    input  logic               eng_xfer_clr,
    input  logic               eng_intr,
    input  logic [NUM_DRV-1:0] irq_ack,
    output logic               start_pulse,
    output logic [CODE_W-1:0]  start_code,
    output logic [SEL_W-1:0]   start_drive,
    output logic [NUM_DRV-1:0] cancel_mask,
    output logic               xfer_on,
    output logic [NUM_DRV-1:0] irq
);

    typedef struct packed {
        logic               err;
        logic               eof;
        logic               eom;
        logic               busy;
        logic               xfer;
        logic [NUM_DRV-1:0] arm;
        logic [NUM_DRV-1:0] pend;
        logic [NUM_DRV-1:0] eot;
        logic [NUM_DRV-1:0] nmt;
        logic [NUM_DRV-1:0] cancel;
        logic               start;
        logic [CODE_W-1:0]  code;
        logic [SEL_W-1:0]   drive;
    } front_st_t;

    front_st_t st_d, st_q;

    op_dec_t            dec_w;
    logic               accept_w;
    logic               clear_w;
    logic [NUM_DRV-1:0] cancel_w;

    tcf_cmd_decode u_decode (
        .code_i (cmd_byte[CODE_W-1:0]),
        .dec_o  (dec_w)
    );

    tcf_accept #(.NUM_DRV(NUM_DRV)) u_accept (
        .cmd_wr_i   (cmd_wr),
        .sel_i      (drv_sel),
        .dec_i      (dec_w),
        .attached_i (drv_attached),
        .wlock_i    (drv_wlock),
        .active_i   (eng_active),
        .stopping_i (eng_stopping),
        .rewind_i   (eng_rewind),
        .accept_o   (accept_w),
        .clear_o    (clear_w),
        .cancel_o   (cancel_w)
    );

    tcf_status_mux #(.NUM_DRV(NUM_DRV)) u_status (
        .sel_i      (drv_sel),
        .err_i      (st_q.err),
        .eof_i      (st_q.eof),
        .busy_i     (st_q.busy),
        .eom_i      (st_q.eom),
        .eot_i      (st_q.eot),
        .nmt_i      (st_q.nmt),
        .attached_i (drv_attached),
        .sts_o      (sts_byte)
    );

    always_comb begin
        st_d        = st_q;
        st_d.start  = 1'b0;
        st_d.cancel = '0;

        // engine side updates
        if (eng_set_err)  st_d.err  = 1'b1;
        if (eng_set_eof)  st_d.eof  = 1'b1;
        if (eng_set_eom)  st_d.eom  = 1'b1;
        if (eng_busy_set) st_d.busy = 1'b1;
        if (eng_busy_clr) st_d.busy = 1'b0;
        if (eng_xfer_clr) st_d.xfer = 1'b0;
        if (eng_set_eot)  st_d.eot[eng_drive] = 1'b1;
        if (eng_set_nmtn) st_d.nmt[eng_drive] = 1'b1;
        st_d.pend = st_q.pend & ~irq_ack;
        if (eng_intr && st_q.arm[eng_drive]) st_d.pend[eng_drive] = 1'b1;

        // arm control rides on every command write
        if (cmd_wr) begin
            if (cmd_byte[CB_ARM])    st_d.arm[drv_sel] = 1'b1;
            if (cmd_byte[CB_DISARM]) st_d.arm[drv_sel] = 1'b0;
        end

        // command side overrides engine updates
        if (clear_w) begin
            st_d.err    = 1'b0;
            st_d.eof    = 1'b0;
            st_d.eom    = 1'b0;
            st_d.busy   = 1'b1;
            st_d.xfer   = 1'b0;
            st_d.arm    = '0;
            st_d.pend   = '0;
            st_d.nmt    = '1;
            st_d.cancel = '1;
        end else if (accept_w) begin
            st_d.err          = 1'b0;
            st_d.eof          = 1'b0;
            st_d.eom          = 1'b0;
            st_d.busy         = dec_w.busy_on_start;
            st_d.xfer         = dec_w.is_xfer;
            st_d.eot[drv_sel] = 1'b0;
            st_d.nmt[drv_sel] = 1'b0;
            st_d.start        = 1'b1;
            st_d.code         = cmd_byte[CODE_W-1:0];
            st_d.drive        = drv_sel;
            st_d.cancel       = cancel_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.busy <= 1'b1;
            st_q.nmt  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_pulse = st_q.start;
    assign start_code  = st_q.code;
    assign start_drive = st_q.drive;
    assign cancel_mask = st_q.cancel;
    assign xfer_on     = st_q.xfer;
    assign irq         = st_q.pend;

    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(cmd_wr)); // R6
    AST_ILLEGAL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !dec_w.legal) |=> !start_pulse); // R1
    AST_ABSENT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !drv_attached[drv_sel]) |=> !start_pulse); // R3
    AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && drv_wlock[drv_sel] &&
         ((cmd_byte[CODE_W-1:0] == OP_WRITE) || (cmd_byte[CODE_W-1:0] == OP_MARK)))
        |=> !start_pulse); // R4
    AST_ACTIVE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && eng_active[drv_sel] && !eng_stopping[drv_sel])
        |=> !start_pulse); // R5
    AST_CANCEL_SPARES_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        ((cancel_mask & $past(eng_rewind)) != '0) |-> $past(clear_w)); // R6
    AST_CLEAR_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        clear_w |=> (sts_byte[SB_BSY] && !start_pulse && (irq == '0))); // R2
    AST_IRQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(irq) & ~$past(st_q.arm)) == '0)); // R11

endmodule

// File: tb/tape_cmd_front_tb_top.sv
`timescale 1ns/1ps
module tape_cmd_front_tb_top;

    localparam int ND = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [1:0] drv_sel = '0;
    logic [7:0] cmd_byte = '0;
    logic [7:0] sts_byte;
    logic [3:0] drv_attached = 4'hF, drv_wlock = '0;
    logic [3:0] eng_active = '0, eng_stopping = '0, eng_rewind = '0;
    logic [1:0] eng_drive = '0;
    logic eng_set_err = 0, eng_set_eof = 0, eng_set_eom = 0, eng_busy_set = 0;
    logic eng_busy_clr = 0, eng_set_eot = 0, eng_set_nmtn = 0, eng_xfer_clr = 0;
    logic eng_intr = 0;
    logic [3:0] irq_ack = '0;
    logic       start_pulse;
    logic [5:0] start_code;
    logic [1:0] start_drive;
    logic [3:0] cancel_mask;
    logic       xfer_on;
    logic [3:0] irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tape_cmd_front #(.NUM_DRV(ND)) dut_i (.*);

    typedef struct packed {
        logic [1:0] sel;
        logic [7:0] cb;
        logic [3:0] att, wlk, act, stp, rew;
        logic       xs;
        logic [3:0] xc;
        logic [7:0] xsts;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 8'h21, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 4'h0, 8'h08}, // R6 R7 read
        '{2'd1, 8'h22, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 4'h0, 8'h00}, // R7 write
        '{2'd2, 8'h38, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 4'h0, 8'h00}, // R7 rewind
        '{2'd3, 8'h23, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 4'h0, 8'h08}, // R1
        '{2'd0, 8'h11, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 4'h0, 8'h08}, // R1
        '{2'd0, 8'h13, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 4'h0, 8'h08}, // R1
        '{2'd0, 8'h30, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 4'h0, 8'h08}, // R1
        '{2'd0, 8'h12, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0, 8'h1C}, // R1 illegal
        '{2'd0, 8'h3F, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0, 8'h1C}, // R1 illegal
        '{2'd0, 8'h00, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0, 8'h1C}, // R1 illegal
        '{2'd1, 8'hE1, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, 4'h0, 8'h08}, // R1 top bits
        '{2'd1, 8'h21, 4'hD, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0, 8'h09}, // R3 R9
        '{2'd2, 8'h22, 4'hF, 4'h4, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0, 8'h1C}, // R4
        '{2'd2, 8'h30, 4'hF, 4'h4, 4'h0, 4'h0, 4'h0, 1'b0, 4'h0, 8'h1C}, // R4
        '{2'd2, 8'h21, 4'hF, 4'h4, 4'h0, 4'h0, 4'h0, 1'b1, 4'h0, 8'h08}, // R4 read ok
        '{2'd0, 8'h21, 4'hF, 4'h0, 4'h1, 4'h0, 4'h0, 1'b0, 4'h0, 8'h1C}, // R5
        '{2'd0, 8'h21, 4'hF, 4'h0, 4'h1, 4'h1, 4'h0, 1'b1, 4'h0, 8'h08}, // R5 stopping
        '{2'd0, 8'h21, 4'hF, 4'h0, 4'hE, 4'h0, 4'h4, 1'b1, 4'hA, 8'h08}, // R6 cancel
        '{2'd3, 8'h22, 4'hF, 4'h0, 4'h9, 4'h8, 4'h0, 1'b1, 4'h1, 8'h00}  // R5 R6
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [1:0] s, input logic [7:0] b);
        @(negedge clk);
        cmd_wr = 1'b1; drv_sel = s; cmd_byte = b;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    localparam int K_ERR = 0, K_EOF = 1, K_EOM = 2, K_BSET = 3, K_BCLR = 4;
    localparam int K_EOT = 5, K_NMT = 6, K_XCLR = 7, K_INT = 8, K_ACK = 9;

    task automatic eng(input int k, input logic [1:0] d);
        @(negedge clk);
        eng_drive = d;
        case (k)
            K_ERR:  eng_set_err  = 1'b1;
            K_EOF:  eng_set_eof  = 1'b1;
            K_EOM:  eng_set_eom  = 1'b1;
            K_BSET: eng_busy_set = 1'b1;
            K_BCLR: eng_busy_clr = 1'b1;
            K_EOT:  eng_set_eot  = 1'b1;
            K_NMT:  eng_set_nmtn = 1'b1;
            K_XCLR: eng_xfer_clr = 1'b1;
            K_INT:  eng_intr     = 1'b1;
            default: irq_ack[d]  = 1'b1;
        endcase
        @(negedge clk);
        {eng_set_err, eng_set_eof, eng_set_eom, eng_busy_set, eng_busy_clr} = '0;
        {eng_set_eot, eng_set_nmtn, eng_xfer_clr, eng_intr} = '0;
        irq_ack = '0;
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 status", 32'(sts_byte), 32'h1C);
        chk("R12 start", 32'(start_pulse), 32'h0);
        chk("R12 irq/cancel/xfer", 32'({irq, cancel_mask, xfer_on}), 32'h0);

        // table walk: clear, then command, then observe
        for (int i = 0; i < NV; i++) begin
            drv_attached = TBL[i].att; drv_wlock = TBL[i].wlk;
            eng_active = TBL[i].act; eng_stopping = TBL[i].stp; eng_rewind = TBL[i].rew;
            do_cmd(TBL[i].sel, 8'h20);
            do_cmd(TBL[i].sel, TBL[i].cb);
            chk($sformatf("R1/R3/R4/R5 start row %0d", i), 32'(start_pulse), 32'(TBL[i].xs));
            if (TBL[i].xs) begin
                chk($sformatf("R6 code row %0d", i), 32'(start_code), 32'(TBL[i].cb[5:0]));
                chk($sformatf("R6 drive row %0d", i), 32'(start_drive), 32'(TBL[i].sel));
            end
            chk($sformatf("R6 cancel row %0d", i), 32'(cancel_mask), 32'(TBL[i].xc));
            chk($sformatf("R7/R8 status row %0d", i), 32'(sts_byte), 32'(TBL[i].xsts));
            @(negedge clk);
            chk($sformatf("R6 single pulse row %0d", i), 32'(start_pulse), 32'h0);
        end
        drv_attached = 4'hF; drv_wlock = '0;
        eng_active = '0; eng_stopping = '0; eng_rewind = '0;

        // R2: clear keeps end of tape, wipes error
        eng(K_EOT, 2'd1);
        eng(K_ERR, 2'd0);
        do_cmd(2'd1, 8'h20);
        chk("R2 keeps eot", 32'(sts_byte), 32'h3C);
        chk("R2 cancel all", 32'(cancel_mask), 32'hF);
        chk("R2 no start", 32'(start_pulse), 32'h0);
        drv_attached = 4'hD; drv_wlock = 4'h2; eng_active = 4'h2; eng_rewind = 4'h2;
        eng(K_ERR, 2'd0);
        do_cmd(2'd1, 8'h20);
        chk("R2 clear absent drive", 32'(sts_byte), 32'h09);
        chk("R2 cancel incl rewind", 32'(cancel_mask), 32'hF);
        drv_attached = 4'hF; drv_wlock = '0; eng_active = '0; eng_rewind = '0;

        // R7 transfer flag
        do_cmd(2'd0, 8'h21);
        chk("R7 xfer read", 32'(xfer_on), 32'h1);
        eng(K_XCLR, 2'd0);
        chk("R7 xfer clr", 32'(xfer_on), 32'h0);
        do_cmd(2'd0, 8'h22);
        chk("R7 xfer write", 32'(xfer_on), 32'h1);
        do_cmd(2'd0, 8'h23);
        chk("R7 xfer space", 32'(xfer_on), 32'h0);

        // R10 / R13 flag build-up on drive 0
        do_cmd(2'd0, 8'h22);
        chk("R7 write status", 32'(sts_byte), 32'h00);
        eng(K_EOF, 2'd0);
        chk("R10 eof gives exc", 32'(sts_byte), 32'h44);
        eng(K_ERR, 2'd0);
        chk("R13 err", 32'(sts_byte), 32'hC4);
        eng(K_EOM, 2'd0);
        chk("R13 eom", 32'(sts_byte), 32'hC6);
        eng(K_BSET, 2'd0);
        chk("R13 busy set", 32'(sts_byte), 32'hCE);
        eng(K_BCLR, 2'd0);
        chk("R13 busy clr", 32'(sts_byte), 32'hC6);
        eng(K_NMT, 2'd0);
        chk("R8 nmtn", 32'(sts_byte), 32'hD6);
        drv_attached = 4'hE;
        #1;
        chk("R9 absent hides nmtn", 32'(sts_byte), 32'hC7);
        drv_attached = 4'hF;
        do_cmd(2'd0, 8'h22);
        eng(K_NMT, 2'd0);
        chk("R10 nmtn alone gives exc", 32'(sts_byte), 32'h14);

        // R13 same-cycle collision
        do_cmd(2'd0, 8'h20);
        @(negedge clk);
        cmd_wr = 1'b1; drv_sel = 2'd0; cmd_byte = 8'h21; eng_set_err = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0; eng_set_err = 1'b0;
        chk("R13 accept beats err", 32'(sts_byte), 32'h08);
        do_cmd(2'd0, 8'h20);
        @(negedge clk);
        cmd_wr = 1'b1; drv_sel = 2'd0; cmd_byte = 8'h00; eng_set_err = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0; eng_set_err = 1'b0;
        chk("R13 ignored keeps err", 32'(sts_byte), 32'h9C);

        // R11 interrupt arming
        do_cmd(2'd2, 8'h20);
        do_cmd(2'd2, 8'h40);
        eng(K_INT, 2'd2);
        chk("R11 armed irq", 32'(irq), 32'h4);
        eng(K_ACK, 2'd2);
        chk("R11 ack", 32'(irq), 32'h0);
        do_cmd(2'd2, 8'h80);
        eng(K_INT, 2'd2);
        chk("R11 disarmed", 32'(irq), 32'h0);
        do_cmd(2'd2, 8'h40);
        do_cmd(2'd2, 8'hC0);
        eng(K_INT, 2'd2);
        chk("R11 disarm wins", 32'(irq), 32'h0);
        do_cmd(2'd3, 8'h40);
        do_cmd(2'd3, 8'h60);
        eng(K_INT, 2'd3);
        chk("R2 clear drops arm", 32'(irq), 32'h0);
        do_cmd(2'd3, 8'h40);
        eng(K_INT, 2'd1);
        chk("R11 unarmed drive", 32'(irq), 32'h0);
        eng(K_INT, 2'd3);
        chk("R11 armed drive 3", 32'(irq), 32'h8);
        do_cmd(2'd0, 8'h20);
        chk("R2 clear drops pending", 32'(irq), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule